// File: doc/BRIEF.md
# Multiplexed Pixel Palette Lookup

This block takes a group of four or five pixels presented side by side, captured all at once on the rising edge of a slow load strobe, and replays them one per pixel clock. Each replayed pixel is converted to 8-bit red, green and blue codes. The colour comes from one of two places:

- a 256-word, 24-bit colour table indexed by the pixel's 8-bit index;
- a four-entry overlay register file chosen by the pixel's 2-bit overlay select.

A per-group blank flag forces the colour to the blanking level. Two configuration bits set the mode. One chooses between four and five pixels per group. The other allows overlay substitution.

The load strobe runs at a quarter or a fifth of the pixel clock rate. It has no fixed phase to that clock, so it is brought into the pixel-clock domain through a two-flop synchroniser and an edge detector. A synchronous write port fills both the colour table and the overlay registers.

Top module: `pxl_palette_mux`

## Requirements
- R1: While reset is held and after it is released with no load strobe, `vid_blank` is 1 and `red`, `green` and `blue` are all 0.
- R2: A pixel that takes its colour from the table produces `red` = word[23:16], `green` = word[15:8] and `blue` = word[7:0]. The word is the last value written at table address `wr_addr` with `wr_ovl` = 0.
- R3: Pixels leave in slot order, slot 0 first. Slot k takes its index from `pix_idx[8k+7:8k]` and its overlay select from `pix_osel[2k+1:2k]`.
- R4: With `five_mode` = 0, exactly slots 0 to 3 are output. The cycle after slot 3 shows `vid_blank` = 1 if no new group has arrived.
- R5: With `five_mode` = 1, exactly slots 0 to 4 are output, and then `vid_blank` = 1.
- R6: With `ovl_en` = 1 and a nonzero overlay select s, the colour is overlay register s. The pixel index has no effect on it.
- R7: With `ovl_en` = 1 and overlay select 0, the colour comes from the table.
- R8: With `ovl_en` = 0, the overlay select has no effect and every pixel uses the table.
- R9: When the group's `pix_show` was 0 at capture, every pixel of the group gives `vid_blank` = 1 and RGB = 0, whatever its index and select.
- R10: Take E1 as the first rising `clk` edge that samples `load` high. Slot 0 appears on the outputs after edge E5. Each later slot appears one edge after the one before it.
- R11: Pixel inputs and `pix_show` are sampled on the rising edge of `load`. Changes after that edge do not affect the group.
- R12: A write with `wr_en` = 1 and `wr_ovl` = 1 loads overlay register `wr_addr[1:0]`. With `wr_ovl` = 0 it loads table word `wr_addr`. No other storage changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Group load strobe, asynchronous to `clk` |
| pix_idx | input | 40 | Table indices, slot k at bits [8k+7:8k] |
| pix_osel | input | 10 | Overlay selects, slot k at bits [2k+1:2k] |
| pix_show | input | 1 | 0 blanks the whole group |
| five_mode | input | 1 | 1: five pixels per group; 0: four pixels per group |
| ovl_en | input | 1 | Allows overlay substitution |
| wr_en | input | 1 | Write strobe |
| wr_ovl | input | 1 | Write target: 1 selects an overlay register, 0 the table |
| wr_addr | input | 8 | Write address |
| wr_data | input | 24 | Write word {red, green, blue} |
| red | output | 8 | Red code |
| green | output | 8 | Green code |
| blue | output | 8 | Blue code |
| vid_blank | output | 1 | Output is at the blanking level |

## Verification
The table is filled with a pattern that gives different red, green and blue values at every address. This means a wrong slot, a wrong byte lane or a stale read each show up as a wrong code.

Groups of four and five pixels use distinct indices, so the stream shows whether the replay order and the group length are correct. Mixed overlay selects under each `ovl_en` setting separate the override path from the select-0 fallback and from the disabled case.

Blanked groups, inputs changed just after the load edge, and a sample one edge before the expected first pixel cover forcing, capture timing and latency.

// File: rtl/pxl_pal_pkg.sv
`timescale 1ns/1ps
package pxl_pal_pkg;
    localparam int IDX_W     = 8;
    localparam int OSEL_W    = 2;
    localparam int CLR_W     = 8;
    localparam int RGB_W     = 3 * CLR_W;
    localparam int TBL_DEPTH = 1 << IDX_W;
    localparam int OVL_DEPTH = 1 << OSEL_W;

    typedef struct packed {
        logic              vld;
        logic              show;
        logic [OSEL_W-1:0] osel;
        logic [IDX_W-1:0]  idx;
    } pix_t;

    typedef struct packed {
        logic [CLR_W-1:0] r;
        logic [CLR_W-1:0] g;
        logic [CLR_W-1:0] b;
    } rgb_t;

    function automatic logic use_overlay(input logic en, input logic [OSEL_W-1:0] sel);
        return en && (sel != '0);
    endfunction
endpackage

// File: rtl/pxl_load_sync.sv
`timescale 1ns/1ps
module pxl_load_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic load_rise
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], load};
    end

    assign load_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        load_rise |=> !load_rise);
endmodule

// File: rtl/pxl_group_serializer.sv
`timescale 1ns/1ps
module pxl_group_serializer
    import pxl_pal_pkg::*;
#(
    parameter int GRP_MAX = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      load_rise,
    input  logic                      five_mode,
    input  logic [GRP_MAX*IDX_W-1:0]  pix_idx,
    input  logic [GRP_MAX*OSEL_W-1:0] pix_osel,
    input  logic                      pix_show,
    output pix_t                      cur
);
    localparam int CNT_W = $clog2(GRP_MAX);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(GRP_MAX - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(GRP_MAX - 2);

    pix_t             hold [GRP_MAX];
    pix_t             pend [GRP_MAX-1];
    logic [CNT_W-1:0] cnt;

    // capture in the strobe domain; held stable for the whole group period
    always_ff @(posedge load) begin
        for (int k = 0; k < GRP_MAX; k++) begin
            hold[k] <= '{vld:  1'b1,
                         show: pix_show,
                         osel: pix_osel[k*OSEL_W +: OSEL_W],
                         idx:  pix_idx[k*IDX_W +: IDX_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            cnt <= '0;
            for (int k = 0; k < GRP_MAX-1; k++) pend[k] <= '0;
        end else if (load_rise) begin
            cur <= hold[0];
            for (int k = 0; k < GRP_MAX-1; k++) pend[k] <= hold[k+1];
            cnt <= five_mode ? LONG_LAST : SHORT_LAST;
        end else if (cnt != '0) begin
            cur <= pend[0];
            for (int k = 0; k < GRP_MAX-2; k++) pend[k] <= pend[k+1];
            pend[GRP_MAX-2] <= '0;
            cnt <= cnt - 1'b1;
        end else begin
            cur <= '0;
        end
    end

    assert_load_emits_R10: assert property (@(posedge clk) disable iff (rst)
        load_rise |=> cur.vld);
    assert_idle_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_rise && cnt == '0) |=> !cur.vld);
    assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_rise && cnt != '0) |=> ((cnt + CNT_W'(1)) == $past(cnt)));
endmodule

// File: rtl/pxl_color_lookup.sv
`timescale 1ns/1ps
module pxl_color_lookup
    import pxl_pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ovl_en,
    input  pix_t             cur,
    input  logic             wr_en,
    input  logic             wr_ovl,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [RGB_W-1:0] wr_data,
    output rgb_t             rgb,
    output logic             vid_blank
);
    logic [RGB_W-1:0] tbl  [TBL_DEPTH];
    logic [RGB_W-1:0] ovlr [OVL_DEPTH];
    logic [RGB_W-1:0] s1_col;
    logic             s1_dark;

    always_ff @(posedge clk) begin
        if (wr_en && !wr_ovl) tbl[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < OVL_DEPTH; k++) ovlr[k] <= '0;
        end else if (wr_en && wr_ovl) begin
            ovlr[wr_addr[OSEL_W-1:0]] <= wr_data;
        end
    end

    // stage 1: source selection and read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_col  <= '0;
            s1_dark <= 1'b1;
        end else begin
            s1_col  <= use_overlay(ovl_en, cur.osel) ? ovlr[cur.osel] : tbl[cur.idx];
            s1_dark <= !(cur.vld && cur.show);
        end
    end

    // stage 2: blank forcing and output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rgb       <= '0;
            vid_blank <= 1'b1;
        end else begin
            rgb       <= s1_dark ? '0 : rgb_t'(s1_col);
            vid_blank <= s1_dark;
        end
    end

    assert_blank_dark_R9: assert property (@(posedge clk) disable iff (rst)
        vid_blank |-> (rgb == '0));
    assert_blank_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (!cur.vld || !cur.show) |=> ##1 vid_blank);

    for (genvar g = 0; g < OVL_DEPTH; g++) begin : g_ovl_chk
        assert_ovl_hold_R12: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_ovl) |=> $stable(ovlr[g]));
    end
endmodule

// File: rtl/pxl_palette_mux.sv
`timescale 1ns/1ps
module pxl_palette_mux
    import pxl_pal_pkg::*;
#(
    parameter int GRP_MAX     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [GRP_MAX*IDX_W-1:0]  pix_idx,
    input  logic [GRP_MAX*OSEL_W-1:0] pix_osel,
    input  logic                      pix_show,
    input  logic                      five_mode,
    input  logic                      ovl_en,
    input  logic                      wr_en,
    input  logic                      wr_ovl,
    input  logic [IDX_W-1:0]          wr_addr,
    input  logic [RGB_W-1:0]          wr_data,
    output logic [CLR_W-1:0]          red,
    output logic [CLR_W-1:0]          green,
    output logic [CLR_W-1:0]          blue,
    output logic                      vid_blank
);
    logic load_rise;
    pix_t cur;
    rgb_t rgb;

    pxl_load_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .load(load), .load_rise(load_rise)
    );

    pxl_group_serializer #(.GRP_MAX(GRP_MAX)) u_ser (
        .clk(clk), .rst(rst), .load(load), .load_rise(load_rise),
        .five_mode(five_mode), .pix_idx(pix_idx), .pix_osel(pix_osel),
        .pix_show(pix_show), .cur(cur)
    );

    pxl_color_lookup u_lut (
        .clk(clk), .rst(rst), .ovl_en(ovl_en), .cur(cur),
        .wr_en(wr_en), .wr_ovl(wr_ovl), .wr_addr(wr_addr), .wr_data(wr_data),
        .rgb(rgb), .vid_blank(vid_blank)
    );

    assign red   = rgb.r;
    assign green = rgb.g;
    assign blue  = rgb.b;
endmodule

// File: tb/pxl_palette_mux_tb.sv
`timescale 1ns/1ps
module pxl_palette_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [39:0] pix_idx = '0;
    logic [9:0]  pix_osel = '0;
    logic        pix_show = 1'b1;
    logic        five_mode = 1'b0;
    logic        ovl_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_ovl = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [7:0]  red, green, blue;
    logic        vid_blank;

    int tests = 0;
    int fails = 0;
    logic [23:0] tbl_m [256];
    logic [23:0] ovl_m [4];

    always #5 clk = ~clk;

    pxl_palette_mux dut_i (
        .clk(clk), .rst(rst), .load(load), .pix_idx(pix_idx), .pix_osel(pix_osel),
        .pix_show(pix_show), .five_mode(five_mode), .ovl_en(ovl_en),
        .wr_en(wr_en), .wr_ovl(wr_ovl), .wr_addr(wr_addr), .wr_data(wr_data),
        .red(red), .green(green), .blue(blue), .vid_blank(vid_blank)
    );

    task automatic chk(input string req, input logic [24:0] act, input logic [24:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic ovl, input logic [7:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ovl = ovl; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (ovl) ovl_m[a[1:0]] = d; else tbl_m[a] = d;
    endtask

    // expected {blank, rgb} for one pixel
    function automatic logic [24:0] expect_pix(input logic [7:0] idx, input logic [1:0] sel,
                                               input logic show, input logic oen);
        if (!show) return {1'b1, 24'h0};
        if (oen && sel != 2'd0) return {1'b0, ovl_m[sel]};
        return {1'b0, tbl_m[idx]};
    endfunction

    task automatic run_group(input string req, input logic [39:0] idx, input logic [9:0] sel,
                             input logic show, input logic five, input logic scramble);
        int n;
        n = five ? 5 : 4;
        @(negedge clk);
        pix_idx = idx; pix_osel = sel; pix_show = show; five_mode = five;
        #1 load = 1'b1;
        if (scramble) begin
            #1 pix_idx = ~idx; pix_osel = ~sel; pix_show = ~show;
        end
        @(negedge clk);               // after E1
        @(negedge clk);               // after E2
        load = 1'b0;
        @(negedge clk);               // after E3
        @(negedge clk);               // after E4: still idle (R10)
        chk({req, " R10 early"}, {vid_blank, red, green, blue}, {1'b1, 24'h0});
        for (int k = 0; k < n; k++) begin
            @(negedge clk);           // after E5+k
            chk($sformatf("%s slot%0d", req, k), {vid_blank, red, green, blue},
                expect_pix(idx[8*k +: 8], sel[2*k +: 2], show, ovl_en));
        end
        @(negedge clk);
        chk({req, " tail R4 R5"}, {vid_blank, red, green, blue}, {1'b1, 24'h0});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {vid_blank, red, green, blue}, {1'b1, 24'h0});
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 after reset", {vid_blank, red, green, blue}, {1'b1, 24'h0});
    endtask

    task automatic t_fill;
        for (int a = 0; a < 256; a++)
            wr_word(1'b0, 8'(a), {8'(a), 8'(~a), 8'(a) ^ 8'h5a});
        wr_word(1'b1, 8'd1, 24'h112233);
        wr_word(1'b1, 8'd2, 24'h445566);
        wr_word(1'b1, 8'd7, 24'h778899);   // R12: lands in overlay 3
        wr_word(1'b1, 8'd0, 24'hABCDEF);
    endtask

    initial begin
        #1_000_000;
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        ovl_en = 1'b0;
        run_group("R2 R3 R4 four", {8'd77, 8'd3, 8'd200, 8'd10}, 10'h0, 1'b1, 1'b0, 1'b0);
        run_group("R3 R5 five", {8'd255, 8'd0, 8'd128, 8'd64, 8'd1}, 10'h0, 1'b1, 1'b1, 1'b0);
        ovl_en = 1'b1;
        run_group("R6 R7 R12 ovl", {8'd9, 8'd8, 8'd7, 8'd6, 8'd5}, {2'd0, 2'd3, 2'd2, 2'd1, 2'd0},
                  1'b1, 1'b1, 1'b0);
        ovl_en = 1'b0;
        run_group("R8 ovl off", {8'd44, 8'd33, 8'd22, 8'd11}, {2'd3, 2'd2, 2'd1, 2'd3},
                  1'b1, 1'b0, 1'b0);
        ovl_en = 1'b1;
        run_group("R9 blank", {8'd1, 8'd2, 8'd3, 8'd4, 8'd5}, {2'd1, 2'd0, 2'd2, 2'd0, 2'd3},
                  1'b0, 1'b1, 1'b0);
        run_group("R11 late change", {8'd15, 8'd25, 8'd35, 8'd45}, {2'd0, 2'd2, 2'd0, 2'd1},
                  1'b1, 1'b0, 1'b1);
        wr_word(1'b0, 8'd25, 24'h0F1E2D);
        ovl_en = 1'b0;
        run_group("R2 rewrite", {8'd26, 8'd25, 8'd24, 8'd25}, 10'h0, 1'b1, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule